// File: doc/BRIEF.md
# Week Timer with Sub-Week Countdown

This block keeps time from a 32.768 kHz reference clock. It has three linked counters. A binary prescaler, free-running while the timer is enabled, gives power-of-two tick rates. A seconds counter advances on each prescaler rollover and raises an alarm when it reaches a programmed compare value. A small down counter, the sub-week counter, runs from a tick source chosen from a rate table and raises its own alarm when it reaches zero. It can optionally reload itself.

Software reaches the block through a simple single-cycle register port. One write strobe carries an address and data. The read data is a combinational function of the read address. Four outputs give one-cycle interrupt pulses: week alarm, sub-week alarm, one-second tick and sub-second tick. Each pulse is also held in a sticky status bit that software clears by writing a one to it. Before reprogramming the timer, software writes zero to the control register, which stops all counting and clears the prescaler.

The sub-week tick table has four slow rates and eleven prescaler taps. The slow rates come from a second divider of `SLOW_DIV` reference cycles, tapped again at /4, /16 and /64. With the default divider of 262 these rates are close to 125, 31.25, 7.8 and 1.95 Hz. The prescaler taps give periods of 1 to 1024 reference cycles.

Top module: `week_timer`

## Requirements
- R1: With the sub-second rate field s (control bits 11:8) nonzero and the timer enabled, `irq_subsec` pulses once every 2^k cycles, where k = min(s-1, PRESC_W). When s = 0 it never pulses.
- R2: While enabled, the seconds counter (address 1) increments once every 2^PRESC_W cycles. The prescaler starts from zero when the timer is enabled. `irq_sec` is high for the one cycle in which the new value first reads back.
- R3: `irq_week` pulses in the cycle in which an increment makes the seconds counter equal the compare register (address 2). Writing the seconds counter to the compare value raises no alarm.
- R4: Each sub-week tick decrements the count (address 3, bits SUB_W-1:0). The tick that moves the count from 1 to 0 pulses `irq_subweek`. With auto-reload off, the count then stays at 0.
- R5: With auto-reload (control bit 1) on, the tick that would make the count 0 instead loads the reload value (address 3, bits 16+). A tick at count 0 also loads it. With reload value L, the alarm repeats every L ticks.
- R6: The sub-week rate field r (control bits 7:4) selects the tick. r = 0 gives no tick. r = 1..4 give periods of SLOW_DIV × 1, 4, 16 and 64 cycles. r = 5..15 give a period of 2^min(r-5, PRESC_W) cycles.
- R7: While control bit 0 (enable) is clear, the prescaler, the slow divider, the seconds counter and the sub-week count do not move, and no interrupt pulses.
- R8: Writes at address 0 (control), 1 (seconds), 2 (compare) and 3 (sub-week reload) act independently. A write at address 3 sets both the reload value and the count. A register write takes priority over a same-cycle count.
- R9: Status (address 4) bits 0 to 3 latch the week, sub-week, second and sub-second pulses one cycle after each pulse. Writing a 1 to a bit clears it, and a new set wins over a same-cycle clear.
- R10: The seconds counter wraps from 2^SEC_W-1 to 0 with its normal `irq_sec` pulse and no other event.
- R11: After reset every register, status bit and interrupt output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, combinational |
| irq_week | output | 1 | Week alarm pulse |
| irq_subweek | output | 1 | Sub-week alarm pulse |
| irq_sec | output | 1 | One-second tick pulse |
| irq_subsec | output | 1 | Sub-second tick pulse |

## Verification
The bench builds the block with PRESC_W = 11 and SLOW_DIV = 10, so one second lasts 2048 cycles and the slow periods are 10, 40, 160 and 640 cycles. With these values, every entry of the sub-week rate table can be measured within a short run, including the clamped taps and two full seconds. Alarm matching and the 28-bit wrap also fall within reach. SEC_W and SUB_W keep their default widths, so the wrap is exercised at the real counter size.

// File: rtl/week_timer.sv
module week_timer #(
  parameter int PRESC_W  = 15,
  parameter int SEC_W    = 28,
  parameter int SUB_W    = 9,
  parameter int SLOW_DIV = 262
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq_week,
  output logic        irq_subweek,
  output logic        irq_sec,
  output logic        irq_subsec
);
  localparam int SLOW_CW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [SLOW_CW-1:0] SLOW_LAST = SLOW_CW'(SLOW_DIV - 1);

  logic               run, autold;
  logic [3:0]         sw_rate, ss_rate;
  logic [PRESC_W-1:0] presc;
  logic [SLOW_CW-1:0] slow;
  logic [5:0]         sdiv;
  logic [SEC_W-1:0]   secs, cmpv;
  logic [SUB_W-1:0]   swcnt, swload;
  logic [3:0]         stat;
  logic [PRESC_W:0]   tap;
  logic               base, sw_tick, ss_tick;

  wire wr_ctl = wr_en && wr_addr == 3'd0;
  wire wr_sec = wr_en && wr_addr == 3'd1;
  wire wr_cmp = wr_en && wr_addr == 3'd2;
  wire wr_sw  = wr_en && wr_addr == 3'd3;
  wire wr_st  = wr_en && wr_addr == 3'd4;
  wire [SEC_W-1:0] sec_nxt = secs + 1'b1;
  wire sec_tick = tap[PRESC_W];

  function automatic int clamp_idx(input int v);
    return (v > PRESC_W) ? PRESC_W : v;
  endfunction

  assign tap[0] = run;
  for (genvar k = 1; k <= PRESC_W; k++) begin : g_tap
    assign tap[k] = run & (&presc[k-1:0]);
  end

  assign base    = run && slow == SLOW_LAST;
  assign ss_tick = (ss_rate != 4'd0) && tap[clamp_idx(int'(ss_rate) - 1)];

  always_comb begin
    case (sw_rate)
      4'd0:    sw_tick = 1'b0;
      4'd1:    sw_tick = base;
      4'd2:    sw_tick = base & (&sdiv[1:0]);
      4'd3:    sw_tick = base & (&sdiv[3:0]);
      4'd4:    sw_tick = base & (&sdiv);
      default: sw_tick = tap[clamp_idx(int'(sw_rate) - 5)];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; autold <= 1'b0; sw_rate <= '0; ss_rate <= '0;
      presc <= '0; slow <= '0; sdiv <= '0;
      secs <= '0; cmpv <= '0; swcnt <= '0; swload <= '0; stat <= '0;
      irq_week <= 1'b0; irq_subweek <= 1'b0; irq_sec <= 1'b0; irq_subsec <= 1'b0;
    end else begin
      if (wr_ctl) begin
        run     <= wr_data[0];
        autold  <= wr_data[1];
        sw_rate <= wr_data[7:4];
        ss_rate <= wr_data[11:8];
      end
      presc <= run ? presc + 1'b1 : '0;
      slow  <= (!run || base) ? '0 : slow + 1'b1;
      sdiv  <= !run ? '0 : (base ? sdiv + 1'b1 : sdiv);

      if (wr_sec)        secs <= wr_data[SEC_W-1:0];
      else if (sec_tick) secs <= sec_nxt;
      if (wr_cmp)        cmpv <= wr_data[SEC_W-1:0];

      if (wr_sw) begin
        swcnt  <= wr_data[SUB_W-1:0];
        swload <= wr_data[SUB_W-1:0];
      end else if (sw_tick) begin
        if (swcnt <= SUB_W'(1)) swcnt <= autold ? swload : '0;
        else                    swcnt <= swcnt - 1'b1;
      end

      irq_sec     <= sec_tick;
      irq_week    <= sec_tick && !wr_sec && sec_nxt == cmpv;
      irq_subsec  <= ss_tick;
      irq_subweek <= !wr_sw && sw_tick && swcnt == SUB_W'(1);
      stat <= (stat & ~(wr_st ? wr_data[3:0] : 4'h0))
              | {irq_subsec, irq_sec, irq_subweek, irq_week};
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = {20'h0, ss_rate, sw_rate, 2'b00, autold, run};
      3'd1:    rd_data = 32'(secs);
      3'd2:    rd_data = 32'(cmpv);
      3'd3:    rd_data = 32'(swcnt) | (32'(swload) << 16);
      3'd4:    rd_data = {28'h0, stat};
      default: rd_data = '0;
    endcase
  end

  assert_sec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !wr_sec) |=> secs == $past(secs) + 1'b1);
  assert_sec_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sec |=> !irq_sec);
  assert_week_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_week |-> secs == $past(cmpv));
  assert_stop_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!autold && swcnt == '0 && !wr_sw) |=> swcnt == '0);
  assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_sw && !wr_sec) |=> ($stable(secs) && $stable(swcnt)));
  assert_status_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_week |=> stat[0]);
endmodule

// File: tb/sim_week_timer.sv
module sim_week_timer;
  localparam int PW = 11;
  localparam int SD = 10;
  localparam int SECM = 1 << 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic irq_week, irq_subweek, irq_sec, irq_subsec;

  week_timer #(.PRESC_W(PW), .SEC_W(28), .SUB_W(9), .SLOW_DIV(SD)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_week(irq_week),
    .irq_subweek(irq_subweek), .irq_sec(irq_sec), .irq_subsec(irq_subsec));

  always #10 clk = ~clk;

  int nvec = 0, nfail = 0, cyc = 0;
  bit done = 0;
  int n_week = 0, n_sw = 0, n_sec = 0, n_ss = 0;
  int last_sec = 0, last_sw = 0, last_stat = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_ctrl = 0, m_presc = 0, m_slow = 0, m_sdiv = 0, m_sec = 0, m_cmp = 0;
  int m_cnt = 0, m_load = 0, m_stat = 0;
  bit m_iw = 0, m_isw = 0, m_is = 0, m_iss = 0;

  function automatic bit tapf(int presc, bit en, int k);
    int kk = (k > PW) ? PW : k;
    if (!en) return 0;
    return (presc % (1 << kk)) == (1 << kk) - 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_presc = 0; m_slow = 0; m_sdiv = 0; m_sec = 0; m_cmp = 0;
      m_cnt = 0; m_load = 0; m_stat = 0; m_iw = 0; m_isw = 0; m_is = 0; m_iss = 0;
    end else begin
      bit en, ar, st, bt, swt, n_iw, n_isw, n_iss;
      int rate, ss, clr, d;
      en = m_ctrl[0]; ar = m_ctrl[1];
      rate = (m_ctrl >> 4) & 15; ss = (m_ctrl >> 8) & 15;
      d = int'(wr_data);
      st = tapf(m_presc, en, PW);
      bt = en && m_slow == SD - 1;
      case (rate)
        0: swt = 0;
        1: swt = bt;
        2: swt = bt && m_sdiv % 4 == 3;
        3: swt = bt && m_sdiv % 16 == 15;
        4: swt = bt && m_sdiv % 64 == 63;
        default: swt = tapf(m_presc, en, rate - 5);
      endcase
      n_iss = ss != 0 && tapf(m_presc, en, ss - 1);
      n_iw = st && !(wr_en && wr_addr == 1) && ((m_sec + 1) % SECM) == m_cmp;
      n_isw = 0;
      if (wr_en && wr_addr == 3) begin
        m_cnt = d & 511; m_load = d & 511;
      end else if (swt) begin
        if (m_cnt == 1) n_isw = 1;
        if (m_cnt <= 1) m_cnt = ar ? m_load : 0;
        else m_cnt = m_cnt - 1;
      end
      clr = (wr_en && wr_addr == 4) ? (d & 15) : 0;
      m_stat = (m_stat & ~clr) | int'(m_iw) | (int'(m_isw) << 1) | (int'(m_is) << 2) | (int'(m_iss) << 3);
      if (wr_en && wr_addr == 1) m_sec = d % SECM;
      else if (st) m_sec = (m_sec + 1) % SECM;
      if (wr_en && wr_addr == 2) m_cmp = d % SECM;
      m_sdiv = !en ? 0 : (bt ? (m_sdiv + 1) % 64 : m_sdiv);
      m_slow = (!en || bt) ? 0 : m_slow + 1;
      m_presc = en ? (m_presc + 1) % (1 << PW) : 0;
      if (wr_en && wr_addr == 0) m_ctrl = d & 'hFF3;
      m_is = st; m_iw = n_iw; m_isw = n_isw; m_iss = n_iss;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  // per-cycle comparison, read sweep and watchdog
  always @(negedge clk) begin
    int exp_rd;
    chk("R3 irq_week", irq_week, m_iw);
    chk("R4 irq_subweek", irq_subweek, m_isw);
    chk("R2 irq_sec", irq_sec, m_is);
    chk("R1 irq_subsec", irq_subsec, m_iss);
    case (rd_addr)
      3'd0: exp_rd = m_ctrl;
      3'd1: exp_rd = m_sec;
      3'd2: exp_rd = m_cmp;
      3'd3: exp_rd = m_cnt | (m_load << 16);
      3'd4: exp_rd = m_stat;
      default: exp_rd = 0;
    endcase
    chk($sformatf("R8 read addr %0d", rd_addr), rd_data, exp_rd);
    if (rd_addr == 1) last_sec = int'(rd_data);
    if (rd_addr == 3) last_sw = int'(rd_data);
    if (rd_addr == 4) last_stat = int'(rd_data);
    n_week += int'(irq_week); n_sw += int'(irq_subweek);
    n_sec += int'(irq_sec); n_ss += int'(irq_subsec);
    rd_addr <= (rd_addr == 3'd4) ? 3'd0 : rd_addr + 3'd1;
    cyc++;
    if (cyc > 190000 && !done) begin
      chk("watchdog expired", 1, 0);
      summary();
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // cycles between two consecutive pulses of the chosen output
  task automatic period(input bit sub, input int lim, output int p);
    int t = 0;
    p = -1;
    while (t < lim && !(sub ? irq_subweek : irq_subsec)) begin @(negedge clk); t++; end
    @(negedge clk);
    t = 1;
    while (t < lim && !(sub ? irq_subweek : irq_subsec)) begin @(negedge clk); t++; end
    if (t < lim) p = t;
  endtask

  initial begin
    int p, b0, b1, b2;
    idle(3);
    chk("R11 irq outputs after reset", {irq_week, irq_subweek, irq_sec, irq_subsec}, 0);
    rst_n = 1'b1;
    idle(6);
    chk("R11 status after reset", last_stat, 0);

    // R6 and R5: reload 1 with auto-reload gives one alarm per tick
    for (int r = 1; r <= 15; r++) begin
      int e;
      e = (r <= 4) ? SD * (1 << (2 * (r - 1))) : (1 << ((r - 5 > PW) ? PW : r - 5));
      wr(0, 0); wr(3, 1); wr(0, 1 | 2 | (r << 4));
      period(1, 3000, p);
      chk($sformatf("R6 tick period code %0d", r), p, e);
    end
    wr(0, 0); wr(3, 3); wr(0, 1 | 2 | (5 << 4));
    period(1, 100, p);
    chk("R5 auto-reload every 3 ticks", p, 3);

    // R6 code 0 gives no tick
    wr(0, 0); wr(3, 2); b0 = n_sw;
    wr(0, 1 | 2);
    idle(300);
    chk("R6 code 0 no alarm", n_sw - b0, 0);
    idle(5);
    chk("R6 code 0 count held", last_sw & 511, 2);

    // R4: no auto-reload stops at zero
    wr(0, 0); wr(3, 3); b0 = n_sw;
    wr(0, 1 | (5 << 4));
    idle(40);
    chk("R4 single alarm", n_sw - b0, 1);
    chk("R4 count stays zero", last_sw & 511, 0);

    // R1 sub-second taps
    wr(0, 0); wr(0, 1 | (3 << 8));
    period(0, 100, p);
    chk("R1 sub-second code 3", p, 4);
    wr(0, 0); wr(0, 1 | (14 << 8));
    period(0, 5000, p);
    chk("R1 sub-second clamped code 14", p, 1 << PW);

    // R2 / R3: seconds count and week alarm
    wr(0, 0); wr(1, 100); wr(2, 102);
    b0 = n_week; b1 = n_sec;
    wr(0, 1);
    idle(2 * (1 << PW) + 20);
    chk("R2 seconds advanced", last_sec, 102);
    chk("R2 second pulses", n_sec - b1, 2);
    chk("R3 one week alarm", n_week - b0, 1);
    idle(6);
    chk("R9 status latched", last_stat & 5, 5);
    wr(4, 15);
    idle(6);
    chk("R9 status cleared", last_stat & 1, 0);

    // R3: writing seconds equal to compare raises nothing
    b0 = n_week;
    wr(1, 102);
    idle(20);
    chk("R3 write no alarm", n_week - b0, 0);

    // R7: disable holds everything
    wr(0, 0); b0 = n_sec; b1 = n_ss; b2 = last_sec;
    idle((1 << PW) + 50);
    chk("R7 no pulses while off", (n_sec - b0) + (n_ss - b1), 0);
    chk("R7 seconds held", last_sec, b2);

    // R10 wrap
    wr(1, SECM - 1); wr(2, 5); b0 = n_week; b1 = n_sec;
    wr(0, 1);
    idle((1 << PW) + 40);
    chk("R10 wrapped to zero", last_sec, 0);
    chk("R10 no alarm on wrap", n_week - b0, 0);
    chk("R10 one second pulse", n_sec - b1, 1);

    done = 1;
    idle(2);
    summary();
  end
endmodule